// File: doc/BRIEF.md
# Configurable Macrocell Storage Cell

This block is the storage element at the output of one logic-array macrocell. A set of static configuration inputs turns it into an edge-triggered D flip-flop, an edge-triggered toggle flip-flop or a level-sensitive D latch. The same inputs set four more things:

- the polarity of the clock or enable,
- the polarity of the data input,
- where the clock comes from: one of several shared block clocks, or the cell's own product-term clock,
- the value the cell holds after power-on.

A second input term is XORed with the main data term in front of the storage input. The surrounding logic uses this correction term to make the cell act as a J-K or S-R flip-flop.

The cell is built as synchronous logic on a fast system clock. It samples every term on that clock, including the block clocks, the product-term clock and the shared reset and preset terms. A rising transition of the polarized clock counts as the active edge. Q changes on the second system clock edge after a new input value is sampled.

An active-low power-on reset does two things. It loads the configured power-up value into Q, and it is the only time the configuration inputs are captured. The block has no streaming data path, so all of its pins are plain levels.

Top module: `mc_storage_cell`

## Requirements
- R1: With `cfg_mode` = 0 or 3 (D register), on an active edge Q takes the effective data. When there is no active edge, Q holds. That includes the inactive edge and both steady clock levels.
- R2: With `cfg_mode` = 1 (toggle register), on an active edge Q inverts if the effective data is 1 and holds if it is 0. At all other times Q holds.
- R3: With `cfg_mode` = 2 (latch), Q follows the effective data while the polarized enable is 0, and holds while it is 1.
- R4: The polarized clock is the selected clock XOR `cfg_en_inv`, and its active edge is its 0-to-1 transition. Setting `cfg_en_inv` = 1 therefore moves the active edge to the falling edge of the source. In latch mode it moves the transparent level to the source being high.
- R5: The effective data equals `data_term` XOR `xor_term` XOR `cfg_din_inv`. Data polarity inversion applies in every mode.
- R6: A 1 on `xor_term` inverts the value the storage element receives. In toggle mode, `xor_term` = 1 with `data_term` = 0 toggles Q.
- R7: With `cfg_async_clk` = 0, the clock source is `bclk[cfg_bclk_sel]` and the other block clocks and `pt_clk` have no effect. With `cfg_async_clk` = 1, the source is `pt_clk` and no block clock has an effect.
- R8: A sampled 1 on `rst_term` forces Q to 0. A sampled 1 on `pst_term` with `rst_term` at 0 forces Q to 1. When both are 1, Q is 0.
- R9: While `rst_n` is 0, Q is set to `cfg_init_one` and the configuration inputs are captured. Changes to the configuration inputs while `rst_n` is 1 have no effect on Q.
- R10: A change on any data, clock or reset/preset term reaches Q on the second rising edge of `clk` after the term is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all terms |
| rst_n | input | 1 | Active-low power-on reset and configuration capture |
| data_term | input | 1 | Main data or toggle product term |
| xor_term | input | 1 | Correction term XORed into the data path |
| bclk | input | NUM_BCLK | Shared block clocks |
| pt_clk | input | 1 | Individual product-term clock |
| rst_term | input | 1 | Shared reset term, active high |
| pst_term | input | 1 | Shared preset term, active high |
| cfg_mode | input | 2 | 0/3 D register, 1 toggle register, 2 latch |
| cfg_en_inv | input | 1 | Invert clock or latch enable |
| cfg_din_inv | input | 1 | Invert effective data |
| cfg_async_clk | input | 1 | 1 selects pt_clk, 0 selects a block clock |
| cfg_bclk_sel | input | SEL_W | Index of the selected block clock |
| cfg_init_one | input | 1 | Power-up value of Q |
| q | output | 1 | Stored value |

## Verification
The assertions assume the configuration is frozen once `rst_n` is high. They also assume that every clock and term is a plain level sampled on `clk`, with no glitch narrower than one sample.

The bench holds each input pattern for three system cycles. Each clock or enable transition is therefore sampled cleanly, and Q settles before the check.

The configuration inputs are loaded only in a reset pulse. While `rst_n` is high, the bench drives them with random values to show they are ignored. The unused block clocks and the unselected clock source are also driven randomly.

// File: rtl/mc_storage_pkg.sv
package mc_storage_pkg;

  typedef enum logic [1:0] {
    MODE_DREG     = 2'd0,
    MODE_TREG     = 2'd1,
    MODE_LATCH    = 2'd2,
    MODE_DREG_ALT = 2'd3
  } cell_mode_e;

  typedef struct packed {
    cell_mode_e mode;
    logic       en_inv;
    logic       din_inv;
    logic       async_clk;
    logic       init_one;
  } cell_cfg_t;

endpackage

// File: rtl/mc_clock_select.sv
module mc_clock_select #(
  parameter int NUM_BCLK = 4,
  localparam int SEL_W = (NUM_BCLK > 1) ? $clog2(NUM_BCLK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_BCLK-1:0] bclk,
  input  logic                pt_clk,
  input  logic                async_clk,
  input  logic [SEL_W-1:0]    bclk_sel,
  input  logic                en_inv,
  output logic                en_level,
  output logic                rise
);

  logic [NUM_BCLK-1:0] pick;
  logic                bclk_mux;
  logic                src;
  logic                pol_q;
  logic                prev_q;

  // One-hot gating of the shared clocks by the select index
  generate
    for (genvar i = 0; i < NUM_BCLK; i++) begin : g_pick
      assign pick[i] = bclk[i] & (bclk_sel == SEL_W'(i));
    end
  endgenerate

  assign bclk_mux = |pick;
  assign src      = async_clk ? pt_clk : bclk_mux;

  // Both stages reset high so no edge is seen until a genuine 0->1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      pol_q  <= src ^ en_inv;
      prev_q <= pol_q;
    end
  end

  assign en_level = pol_q;
  assign rise     = pol_q & ~prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R4

endmodule

// File: rtl/mc_input_stage.sv
module mc_input_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic data_term,
  input  logic xor_term,
  input  logic din_inv,
  input  logic rst_term,
  input  logic pst_term,
  output logic eff_s,
  output logic clr_s,
  output logic pre_s
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_s <= 1'b0;
      clr_s <= 1'b0;
      pre_s <= 1'b0;
    end else begin
      eff_s <= data_term ^ xor_term ^ din_inv;
      clr_s <= rst_term;
      pre_s <= pst_term;
    end
  end

endmodule

// File: rtl/mc_storage_core.sv
module mc_storage_core
  import mc_storage_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cell_mode_e mode,
  input  logic       init_one,
  input  logic       rise,
  input  logic       en_level,
  input  logic       eff,
  input  logic       clr,
  input  logic       pre,
  output logic       q
);

  logic is_treg;
  logic is_latch;
  logic q_next;

  assign is_treg  = (mode == MODE_TREG);
  assign is_latch = (mode == MODE_LATCH);

  always_comb begin
    q_next = q;
    if (clr) begin
      q_next = 1'b0;
    end else if (pre) begin
      q_next = 1'b1;
    end else if (is_latch) begin
      if (!en_level) q_next = eff;
    end else if (rise) begin
      q_next = is_treg ? (q ^ eff) : eff;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= init_one;
    else        q <= q_next;
  end

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q); // R8
  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (pre && !clr) |=> q); // R8
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_latch && !rise && !clr && !pre) |=> $stable(q)); // R1
  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_treg && rise && eff && !clr && !pre) |=> (q != $past(q))); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_latch && en_level && !clr && !pre) |=> $stable(q)); // R3
  AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_latch && !en_level && !clr && !pre) |=> (q == $past(eff))); // R3

endmodule

// File: rtl/mc_storage_cell.sv
module mc_storage_cell
  import mc_storage_pkg::*;
#(
  parameter int NUM_BCLK = 4,
  localparam int SEL_W = (NUM_BCLK > 1) ? $clog2(NUM_BCLK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_term,
  input  logic                xor_term,
  input  logic [NUM_BCLK-1:0] bclk,
  input  logic                pt_clk,
  input  logic                rst_term,
  input  logic                pst_term,
  input  logic [1:0]          cfg_mode,
  input  logic                cfg_en_inv,
  input  logic                cfg_din_inv,
  input  logic                cfg_async_clk,
  input  logic [SEL_W-1:0]    cfg_bclk_sel,
  input  logic                cfg_init_one,
  output logic                q
);

  cell_cfg_t        cfg_q;
  logic [SEL_W-1:0] sel_q;
  logic             en_level;
  logic             rise;
  logic             eff_s;
  logic             clr_s;
  logic             pre_s;

  // Configuration is captured only while power-on reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.mode      <= cell_mode_e'(cfg_mode);
      cfg_q.en_inv    <= cfg_en_inv;
      cfg_q.din_inv   <= cfg_din_inv;
      cfg_q.async_clk <= cfg_async_clk;
      cfg_q.init_one  <= cfg_init_one;
      sel_q           <= cfg_bclk_sel;
    end
  end

  mc_clock_select #(.NUM_BCLK(NUM_BCLK)) u_clk_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk      (bclk),
    .pt_clk    (pt_clk),
    .async_clk (cfg_q.async_clk),
    .bclk_sel  (sel_q),
    .en_inv    (cfg_q.en_inv),
    .en_level  (en_level),
    .rise      (rise)
  );

  mc_input_stage u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_term (data_term),
    .xor_term  (xor_term),
    .din_inv   (cfg_q.din_inv),
    .rst_term  (rst_term),
    .pst_term  (pst_term),
    .eff_s     (eff_s),
    .clr_s     (clr_s),
    .pre_s     (pre_s)
  );

  // The reset value of Q comes straight from the port: in the cycle the
  // power-on reset is sampled, the captured copy is not loaded yet.
  mc_storage_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cfg_q.mode),
    .init_one (cfg_init_one),
    .rise     (rise),
    .en_level (en_level),
    .eff      (eff_s),
    .clr      (clr_s),
    .pre      (pre_s),
    .q        (q)
  );

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($stable(cfg_q) && $stable(sel_q))); // R9

endmodule

// File: tb/mc_storage_cell_bench.sv
module mc_storage_cell_bench;

  localparam int NUM_BCLK = 4;
  localparam int SEL_W = 2;
  localparam int OPS_PER_CFG = 24;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                data_term = 1'b0;
  logic                xor_term = 1'b0;
  logic [NUM_BCLK-1:0] bclk = '0;
  logic                pt_clk = 1'b0;
  logic                rst_term = 1'b0;
  logic                pst_term = 1'b0;
  logic [1:0]          cfg_mode = 2'd0;
  logic                cfg_en_inv = 1'b0;
  logic                cfg_din_inv = 1'b0;
  logic                cfg_async_clk = 1'b0;
  logic [SEL_W-1:0]    cfg_bclk_sel = '0;
  logic                cfg_init_one = 1'b0;
  logic                q;

  int checks = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  mc_storage_cell #(.NUM_BCLK(NUM_BCLK)) u_mc_storage_cell (
    .clk           (clk),
    .rst_n         (rst_n),
    .data_term     (data_term),
    .xor_term      (xor_term),
    .bclk          (bclk),
    .pt_clk        (pt_clk),
    .rst_term      (rst_term),
    .pst_term      (pst_term),
    .cfg_mode      (cfg_mode),
    .cfg_en_inv    (cfg_en_inv),
    .cfg_din_inv   (cfg_din_inv),
    .cfg_async_clk (cfg_async_clk),
    .cfg_bclk_sel  (cfg_bclk_sel),
    .cfg_init_one  (cfg_init_one),
    .q             (q)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: q=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] m;
    logic       inv, dinv, asy, init1;
    logic [SEL_W-1:0] sel;
    logic       mq, mprev, p, e;
    string      tag;
    for (int cm = 0; cm < 4; cm++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int cd = 0; cd < 2; cd++) begin
          for (int cs = 0; cs < 5; cs++) begin
            for (int cp = 0; cp < 2; cp++) begin
              m = 2'(cm); inv = 1'(ci); dinv = 1'(cd);
              asy = (cs == 4); sel = SEL_W'(cs); init1 = 1'(cp);
              // Power-on reset with this configuration
              @(negedge clk);
              rst_n = 1'b0;
              cfg_mode = m; cfg_en_inv = inv; cfg_din_inv = dinv;
              cfg_async_clk = asy; cfg_bclk_sel = sel; cfg_init_one = init1;
              rst_term = 1'b0; pst_term = 1'b0;
              repeat (2) @(negedge clk);
              rst_n = 1'b1;
              check("R9 reset value", q, init1);
              mq = init1;
              mprev = 1'b1;
              for (int op = 0; op < OPS_PER_CFG; op++) begin
                seed = next_rand(seed);
                data_term = seed[0];
                xor_term  = seed[1];
                bclk      = seed[5:2];
                pt_clk    = seed[6];
                rst_term  = (seed[11:8] == 4'd0);
                pst_term  = (seed[15:12] == 4'd0);
                // R9: scrambled configuration must be ignored after reset
                cfg_mode      = seed[17:16];
                cfg_en_inv    = seed[18];
                cfg_din_inv   = seed[19];
                cfg_async_clk = seed[20];
                cfg_bclk_sel  = seed[22:21];
                cfg_init_one  = seed[23];
                // Model: R4 polarity, R7 source, R5/R6 effective data
                p = (asy ? pt_clk : bclk[sel]) ^ inv;
                e = data_term ^ xor_term ^ dinv;
                if (m == 2'd2) begin
                  if (!p) mq = e;
                  tag = "R3 latch";
                end else begin
                  if (p && !mprev) mq = (m == 2'd1) ? (mq ^ e) : e;
                  tag = (m == 2'd1) ? "R2 toggle reg" : "R1 D reg";
                end
                mprev = p;
                if (rst_term) begin
                  mq = 1'b0;
                  tag = "R8 reset term";
                end else if (pst_term) begin
                  mq = 1'b1;
                  tag = "R8 preset term";
                end
                // R10: three sample cycles cover the two-edge latency
                repeat (3) @(negedge clk);
                check(tag, q, mq);
              end
            end
          end
        end
      end
    end
    // Directed corner: reset and preset together, reset wins (R8)
    @(negedge clk);
    rst_term = 1'b1; pst_term = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset beats preset", q, 1'b0);
    rst_term = 1'b0; pst_term = 1'b0;
    // Directed corner: xor term alone toggles a toggle register (R6)
    @(negedge clk);
    rst_n = 1'b0;
    cfg_mode = 2'd1; cfg_en_inv = 1'b0; cfg_din_inv = 1'b0;
    cfg_async_clk = 1'b1; cfg_init_one = 1'b0;
    data_term = 1'b0; xor_term = 1'b1; pt_clk = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    pt_clk = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 xor toggles", q, 1'b1);
    // Falling source edge is inactive without inversion (R4)
    pt_clk = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 inactive edge holds", q, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule